// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of every line of a small direct-mapped, write-back cache. The cache shares one snooping bus with other caches. Each line holds a tag and one of four states: Invalid, Shared, Exclusive or Modified. The local CPU sends read, write, flush and evict requests. The controller answers a request at once when the line's state allows it. Otherwise it runs one bus transaction at a time: a line read, a read-for-ownership that invalidates other copies, or a write-back of dirty data. The outside responder ends each transaction with a one-cycle completion pulse. On a line read, that responder also reports whether another cache holds a copy.

In parallel, the controller watches the reads and ownership requests of other caches. It answers them in the same cycle. A read that matches a clean line gets a "copy held" signal. A request that matches a dirty line gets a retry. The controller then writes that dirty line back before it accepts any more CPU work, which lets the other cache's retried request find memory up to date.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus transaction is pending and `cpu_ready` is high whenever `snp_valid` is low.
- R2: A read (`cpu_op` 00) to a line held in Modified, Exclusive or Shared completes with no bus transaction. A read miss issues a line read (`bus_req_cmd` 00). That read installs the line in Exclusive when `bus_shared` is low at completion, and in Shared when it is high.
- R3: A write (`cpu_op` 01) to a line in Exclusive or Modified completes with no bus transaction and leaves the line Modified.
- R4: A write to a Shared line first issues a read-for-ownership (`bus_req_cmd` 01), then leaves the line Modified.
- R5: A write miss issues exactly one read-for-ownership, with no line read before it, and installs the new line in Modified.
- R6: When a miss displaces a Modified line, a write-back (`bus_req_cmd` 10) of the old address comes first. A clean displaced line causes no write-back. An evict (`cpu_op` 11) drops a clean line with no bus transaction, and drops a Modified line only after writing it back.
- R7: A flush (`cpu_op` 10) of a Modified line writes it back and leaves it Exclusive. A flush of a clean line issues nothing.
- R8: A snooped read or ownership request (`snp_cmd` 0 or 1) that matches a Modified line raises `snp_retry` in the same cycle. It also raises `cpu_ready` low from the next cycle until a write-back of that line completes, after which the line is Shared.
- R9: A snooped read that matches a Shared or Exclusive line raises `snp_shared` and never `snp_retry`. An Exclusive line becomes Shared.
- R10: A snooped ownership request that matches a Shared or Exclusive line makes it Invalid, with neither `snp_retry` nor `snp_shared`.
- R11: A Shared line is never promoted to Exclusive. A later write still issues a read-for-ownership, even when no other copy exists.
- R12: A snoop whose tag differs from the stored one, or that hits an Invalid line, raises no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_op | input | 2 | 00 read, 01 write, 10 flush, 11 evict |
| cpu_addr | input | ADDR_W | Line address: low bits index, high bits tag |
| cpu_ready | output | 1 | Request accepted in a cycle where `cpu_valid` is also high |
| cpu_done | output | 1 | One-cycle pulse when an accepted request finishes |
| bus_req_valid | output | 1 | Bus transaction outstanding |
| bus_req_cmd | output | 2 | 00 line read, 01 read-for-ownership, 10 write-back, 11 none |
| bus_req_addr | output | ADDR_W | Line address of the transaction |
| bus_done | input | 1 | One-cycle completion of the outstanding transaction |
| bus_shared | input | 1 | Another cache holds the line (sampled with `bus_done`) |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_cmd | input | 1 | 0 read, 1 ownership request or invalidate |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_retry | output | 1 | Requester must back off (dirty copy held here) |
| snp_shared | output | 1 | A clean copy is held here |

## Verification
The hardest case to reach is a forced write-back: a line must first be made Modified before any snoop can hit it that way. The stimulus does this by filling a line with the copy-held signal low and then writing to it locally. Only after that does it snoop a read at the same address. The scoreboard then expects a write-back of that exact address before the CPU is served again. A second snoop must then see a clean copy with no retry. The same approach, with an ownership request instead of a read, reaches the dirty-then-invalidate path.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'b00,
        OP_WR    = 2'b01,
        OP_FLUSH = 2'b10,
        OP_EVICT = 2'b11
    } cpu_op_e;

    typedef enum logic [1:0] {
        BC_RD   = 2'b00,
        BC_RFO  = 2'b01,
        BC_WB   = 2'b10,
        BC_NONE = 2'b11
    } bus_cmd_e;

    typedef enum logic [2:0] {
        PU_SNPWB,
        PU_FLUSH,
        PU_EVICT,
        PU_VICTIM,
        PU_FILL
    } purpose_e;

    typedef struct packed {
        bus_cmd_e cmd;
        purpose_e purp;
    } xact_t;

    // State a clean line takes after a snooped request matches it.
    function automatic mesi_e snoop_next(mesi_e cur, logic is_own);
        case (cur)
            ST_E, ST_S: return is_own ? ST_I : ST_S;
            default:    return cur;
        endcase
    endfunction

    // State installed when a fill transaction completes.
    function automatic mesi_e fill_state(bus_cmd_e cmd, logic others_hold);
        if (cmd == BC_RFO) return ST_M;
        return others_hold ? ST_S : ST_E;
    endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
    import mesi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fsm_we,
    input  logic [IDX_W-1:0]            fsm_idx,
    input  mesi_e                       fsm_st,
    input  logic                        fsm_tag_we,
    input  logic [TAG_W-1:0]            fsm_tag,
    input  logic                        snp_we,
    input  logic [IDX_W-1:0]            snp_idx,
    input  mesi_e                       snp_st,
    output mesi_e [LINES-1:0]           st_q,
    output logic  [LINES-1:0][TAG_W-1:0] tag_q
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        mesi_e            st_r;
        logic [TAG_W-1:0] tag_r;

        // Controller updates win over snoop updates on the same line.
        always_ff @(posedge clk) begin
            if (rst) begin
                st_r  <= ST_I;
                tag_r <= '0;
            end else if (fsm_we && fsm_idx == IDX_W'(g)) begin
                st_r <= fsm_st;
                if (fsm_tag_we) tag_r <= fsm_tag;
            end else if (snp_we && snp_idx == IDX_W'(g)) begin
                st_r <= snp_st;
            end
        end

        assign st_q[g]  = st_r;
        assign tag_q[g] = tag_r;
    end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic                         snp_valid,
    input  logic                         snp_cmd,
    input  logic [IDX_W-1:0]             snp_idx,
    input  logic [TAG_W-1:0]             snp_tag,
    input  mesi_e [LINES-1:0]            st_q,
    input  logic  [LINES-1:0][TAG_W-1:0] tag_q,
    output logic                         snp_retry,
    output logic                         snp_shared,
    output logic                         upd_we,
    output mesi_e                        upd_st
);

    mesi_e cur;
    logic  match;

    assign cur        = st_q[snp_idx];
    assign match      = snp_valid && (cur != ST_I) && (tag_q[snp_idx] == snp_tag);
    assign snp_retry  = match && (cur == ST_M);
    assign snp_shared = match && (cur != ST_M) && !snp_cmd;
    assign upd_st     = snoop_next(cur, snp_cmd);
    assign upd_we     = match && (cur != ST_M) && (upd_st != cur);

endmodule

// File: rtl/mesi_ctrl_fsm.sv
module mesi_ctrl_fsm
    import mesi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cpu_valid,
    input  cpu_op_e                      cpu_op,
    input  logic [IDX_W-1:0]             cpu_idx,
    input  logic [TAG_W-1:0]             cpu_tag,
    input  logic                         snp_valid,
    input  logic                         pend_set,
    input  logic [IDX_W-1:0]             pend_idx,
    input  mesi_e [LINES-1:0]            st_q,
    input  logic  [LINES-1:0][TAG_W-1:0] tag_q,
    input  logic                         bus_done,
    input  logic                         bus_shared,
    output logic                         cpu_ready,
    output logic                         cpu_done,
    output logic                         bus_req_valid,
    output bus_cmd_e                     bus_req_cmd,
    output logic [TAG_W+IDX_W-1:0]       bus_req_addr,
    output logic                         fsm_we,
    output logic [IDX_W-1:0]             fsm_idx,
    output mesi_e                        fsm_st,
    output logic                         fsm_tag_we,
    output logic [TAG_W-1:0]             fsm_tag
);

    logic             busy_q, busy_d;
    xact_t            xa_q, xa_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [TAG_W-1:0] wb_tag_q, wb_tag_d, new_tag_q, new_tag_d;
    cpu_op_e          op_q, op_d;
    logic             done_q, done_d;
    logic [LINES-1:0] pend_q;
    logic             clr;
    logic [IDX_W-1:0] pick;
    logic             any_pend, accept, c_hit;
    mesi_e            c_st;
    bus_cmd_e         fill_cmd;

    always_comb begin
        pick = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend_q[i]) pick = IDX_W'(i);
        end
    end

    assign any_pend  = |pend_q;
    assign cpu_ready = !busy_q && !any_pend && !snp_valid;
    assign accept    = cpu_valid && cpu_ready;
    assign c_st      = st_q[cpu_idx];
    assign c_hit     = (c_st != ST_I) && (tag_q[cpu_idx] == cpu_tag);
    assign fill_cmd  = (cpu_op == OP_WR) ? BC_RFO : BC_RD;

    always_comb begin
        busy_d     = busy_q;
        xa_d       = xa_q;
        idx_d      = idx_q;
        wb_tag_d   = wb_tag_q;
        new_tag_d  = new_tag_q;
        op_d       = op_q;
        done_d     = 1'b0;
        fsm_we     = 1'b0;
        fsm_idx    = idx_q;
        fsm_st     = ST_I;
        fsm_tag_we = 1'b0;
        fsm_tag    = new_tag_q;
        clr        = 1'b0;
        if (!busy_q) begin
            if (any_pend) begin
                idx_d   = pick;
                fsm_idx = pick;
                if (st_q[pick] == ST_M) begin
                    busy_d   = 1'b1;
                    xa_d     = '{cmd: BC_WB, purp: PU_SNPWB};
                    wb_tag_d = tag_q[pick];
                end else begin
                    clr = 1'b1;
                end
            end else if (accept) begin
                idx_d     = cpu_idx;
                fsm_idx   = cpu_idx;
                op_d      = cpu_op;
                new_tag_d = cpu_tag;
                wb_tag_d  = tag_q[cpu_idx];
                case (cpu_op)
                    OP_RD, OP_WR: begin
                        if (c_hit && (cpu_op == OP_RD || c_st != ST_S)) begin
                            if (cpu_op == OP_WR) begin
                                fsm_we = 1'b1;
                                fsm_st = ST_M;
                            end
                            done_d = 1'b1;
                        end else if (c_hit) begin
                            busy_d = 1'b1;
                            xa_d   = '{cmd: BC_RFO, purp: PU_FILL};
                        end else if (c_st == ST_M) begin
                            busy_d = 1'b1;
                            xa_d   = '{cmd: BC_WB, purp: PU_VICTIM};
                        end else begin
                            busy_d = 1'b1;
                            xa_d   = '{cmd: fill_cmd, purp: PU_FILL};
                        end
                    end
                    OP_FLUSH: begin
                        if (c_hit && c_st == ST_M) begin
                            busy_d = 1'b1;
                            xa_d   = '{cmd: BC_WB, purp: PU_FLUSH};
                        end else begin
                            done_d = 1'b1;
                        end
                    end
                    default: begin
                        if (c_hit && c_st == ST_M) begin
                            busy_d = 1'b1;
                            xa_d   = '{cmd: BC_WB, purp: PU_EVICT};
                        end else begin
                            if (c_hit) fsm_we = 1'b1;
                            done_d = 1'b1;
                        end
                    end
                endcase
            end
        end else if (bus_done) begin
            fsm_we = 1'b1;
            case (xa_q.purp)
                PU_SNPWB: begin
                    fsm_st = ST_S;
                    clr    = 1'b1;
                    busy_d = 1'b0;
                end
                PU_FLUSH: begin
                    fsm_st = ST_E;
                    clr    = 1'b1;
                    busy_d = 1'b0;
                    done_d = 1'b1;
                end
                PU_EVICT: begin
                    fsm_st = ST_I;
                    clr    = 1'b1;
                    busy_d = 1'b0;
                    done_d = 1'b1;
                end
                PU_VICTIM: begin
                    fsm_st = ST_I;
                    clr    = 1'b1;
                    xa_d   = '{cmd: (op_q == OP_WR) ? BC_RFO : BC_RD, purp: PU_FILL};
                end
                default: begin
                    fsm_st     = fill_state(xa_q.cmd, bus_shared);
                    fsm_tag_we = 1'b1;
                    busy_d     = 1'b0;
                    done_d     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            xa_q      <= '{cmd: BC_NONE, purp: PU_FILL};
            idx_q     <= '0;
            wb_tag_q  <= '0;
            new_tag_q <= '0;
            op_q      <= OP_RD;
            done_q    <= 1'b0;
            pend_q    <= '0;
        end else begin
            busy_q    <= busy_d;
            xa_q      <= xa_d;
            idx_q     <= idx_d;
            wb_tag_q  <= wb_tag_d;
            new_tag_q <= new_tag_d;
            op_q      <= op_d;
            done_q    <= done_d;
            pend_q    <= (pend_q & ~(LINES'(clr) << fsm_idx))
                       | (LINES'(pend_set) << pend_idx);
        end
    end

    assign cpu_done      = done_q;
    assign bus_req_valid = busy_q;
    assign bus_req_cmd   = busy_q ? xa_q.cmd : BC_NONE;
    assign bus_req_addr  = {(xa_q.cmd == BC_WB) ? wb_tag_q : new_tag_q, idx_q};

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_done,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic              snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_retry,
    output logic              snp_shared
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    mesi_e [LINES-1:0]            st_q;
    logic  [LINES-1:0][TAG_W-1:0] tag_q;
    logic                         fsm_we, fsm_tag_we, snp_we;
    logic [IDX_W-1:0]             fsm_idx;
    logic [TAG_W-1:0]             fsm_tag;
    mesi_e                        fsm_st, snp_st;
    bus_cmd_e                     cmd;

    mesi_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .fsm_we     (fsm_we),
        .fsm_idx    (fsm_idx),
        .fsm_st     (fsm_st),
        .fsm_tag_we (fsm_tag_we),
        .fsm_tag    (fsm_tag),
        .snp_we     (snp_we),
        .snp_idx    (snp_addr[IDX_W-1:0]),
        .snp_st     (snp_st),
        .st_q       (st_q),
        .tag_q      (tag_q)
    );

    mesi_snoop_unit #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_idx    (snp_addr[IDX_W-1:0]),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .st_q       (st_q),
        .tag_q      (tag_q),
        .snp_retry  (snp_retry),
        .snp_shared (snp_shared),
        .upd_we     (snp_we),
        .upd_st     (snp_st)
    );

    mesi_ctrl_fsm #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cpu_valid     (cpu_valid),
        .cpu_op        (cpu_op_e'(cpu_op)),
        .cpu_idx       (cpu_addr[IDX_W-1:0]),
        .cpu_tag       (cpu_addr[ADDR_W-1:IDX_W]),
        .snp_valid     (snp_valid),
        .pend_set      (snp_retry),
        .pend_idx      (snp_addr[IDX_W-1:0]),
        .st_q          (st_q),
        .tag_q         (tag_q),
        .bus_done      (bus_done),
        .bus_shared    (bus_shared),
        .cpu_ready     (cpu_ready),
        .cpu_done      (cpu_done),
        .bus_req_valid (bus_req_valid),
        .bus_req_cmd   (cmd),
        .bus_req_addr  (bus_req_addr),
        .fsm_we        (fsm_we),
        .fsm_idx       (fsm_idx),
        .fsm_st        (fsm_st),
        .fsm_tag_we    (fsm_tag_we),
        .fsm_tag       (fsm_tag)
    );

    assign bus_req_cmd = cmd;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_done,
    input logic              snp_valid,
    input logic              snp_cmd,
    input logic              snp_retry,
    input logic              snp_shared
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_req_valid && !cpu_done)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_done) |=> (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))); // R2

    AST_RETRY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        snp_retry |-> (snp_valid && !snp_shared)); // R8

    AST_RETRY_BLOCKS_CPU: assert property (@(posedge clk) disable iff (rst)
        snp_retry |=> !cpu_ready); // R8

    AST_SHARED_ON_READ: assert property (@(posedge clk) disable iff (rst)
        snp_shared |-> (snp_valid && !snp_cmd)); // R9

    AST_ONE_XACT: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> !cpu_ready); // R6

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_ready     (cpu_ready),
    .cpu_done      (cpu_done),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (bus_req_cmd),
    .bus_req_addr  (bus_req_addr),
    .bus_done      (bus_done),
    .snp_valid     (snp_valid),
    .snp_cmd       (snp_cmd),
    .snp_retry     (snp_retry),
    .snp_shared    (snp_shared)
);

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb;

    localparam int ADDR_W = 8;
    localparam logic [1:0] RD = 2'b00, WR = 2'b01, FL = 2'b10, EV = 2'b11;
    localparam logic [1:0] B_RD = 2'b00, B_RFO = 2'b01, B_WB = 2'b10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_valid = 1'b0;
    logic [1:0]        cpu_op = 2'b00;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_ready, cpu_done;
    logic              bus_req_valid;
    logic [1:0]        bus_req_cmd;
    logic [ADDR_W-1:0] bus_req_addr;
    logic              bus_done = 1'b0;
    logic              bus_shared = 1'b0;
    logic              snp_valid = 1'b0;
    logic              snp_cmd = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_retry, snp_shared;

    mesi_line_ctrl #(.ADDR_W(ADDR_W), .LINES(4)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
        .bus_done(bus_done), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_retry(snp_retry), .snp_shared(snp_shared)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int n_bus = 0;
    int rsp_cnt = 0;
    logic shared_next = 1'b0;
    logic [ADDR_W+1:0] exp_q[$];
    logic [ADDR_W+1:0] mon_exp;

    task automatic check(logic [31:0] act, logic [31:0] exp, string req, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_bus(logic [1:0] cmd, logic [ADDR_W-1:0] a);
        exp_q.push_back({cmd, a});
    endtask

    // Memory responder: completes each transaction two cycles after it appears.
    always @(negedge clk) begin
        if (rst) begin
            bus_done = 1'b0;
            rsp_cnt  = 0;
        end else if (bus_done) begin
            bus_done = 1'b0;
            rsp_cnt  = 0;
        end else if (bus_req_valid) begin
            rsp_cnt++;
            if (rsp_cnt == 2) begin
                bus_done   = 1'b1;
                bus_shared = shared_next;
            end
        end
    end

    // Scoreboard monitor: compare each completed transaction with the queue head.
    always @(posedge clk) begin
        if (!rst && bus_req_valid && bus_done) begin
            n_bus++;
            if (exp_q.size() == 0) begin
                check({22'd0, bus_req_cmd, bus_req_addr}, 32'hFFFF, "R2", "unexpected bus transaction");
            end else begin
                mon_exp = exp_q.pop_front();
                check({22'd0, bus_req_cmd, bus_req_addr}, {22'd0, mon_exp}, "R6", "bus transaction order");
            end
        end
    end

    task automatic do_cpu(logic [1:0] op, logic [ADDR_W-1:0] a, int nbus, string req);
        int start = n_bus;
        int t = 0;
        @(negedge clk);
        while (!cpu_ready && t < 100) begin @(negedge clk); t++; end
        cpu_valid = 1'b1;
        cpu_op    = op;
        cpu_addr  = a;
        @(negedge clk);
        cpu_valid = 1'b0;
        t = 0;
        while (!cpu_done && t < 100) begin @(negedge clk); t++; end
        check({31'd0, cpu_done}, 1, req, "request completes");
        check(n_bus - start, nbus, req, "bus transaction count");
        check(exp_q.size(), 0, req, "expected transactions left");
    endtask

    task automatic do_snoop(logic own, logic [ADDR_W-1:0] a, logic exp_retry, logic exp_sh, string req);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = own;
        snp_addr  = a;
        #1;
        check({31'd0, snp_retry}, {31'd0, exp_retry}, req, "snoop retry");
        check({31'd0, snp_shared}, {31'd0, exp_sh}, req, "snoop copy held");
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic settle(int start, int nbus, string req);
        int t = 0;
        @(negedge clk);
        check({31'd0, cpu_ready}, 0, req, "cpu blocked during forced write-back");
        while (!(cpu_ready && !bus_req_valid) && t < 100) begin @(negedge clk); t++; end
        check(n_bus - start, nbus, req, "forced write-back count");
        check(exp_q.size(), 0, req, "expected transactions left");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle and ready after reset, and no line answers a snoop
        check({31'd0, cpu_ready}, 1, "R1", "ready after reset");
        check({31'd0, bus_req_valid}, 0, "R1", "no bus request after reset");
        do_snoop(1'b0, 8'h05, 1'b0, 1'b0, "R1");

        // R2 exclusive fill, R3 silent write to Exclusive
        shared_next = 1'b0;
        expect_bus(B_RD, 8'h05);
        do_cpu(RD, 8'h05, 1, "R2");
        do_cpu(WR, 8'h05, 0, "R3");

        // R8 snooped read of a Modified line forces a write-back and demotes to Shared
        expect_bus(B_WB, 8'h05);
        s = n_bus;
        do_snoop(1'b0, 8'h05, 1'b1, 1'b0, "R8");
        settle(s, 1, "R8");
        do_snoop(1'b0, 8'h05, 1'b0, 1'b1, "R8");
        do_cpu(RD, 8'h05, 0, "R2");
        expect_bus(B_RFO, 8'h05);
        do_cpu(WR, 8'h05, 1, "R4");
        do_cpu(WR, 8'h05, 0, "R3");

        // R7 flush keeps the line as Exclusive; a clean flush is silent
        expect_bus(B_WB, 8'h05);
        do_cpu(FL, 8'h05, 1, "R7");
        do_cpu(FL, 8'h05, 0, "R7");
        do_cpu(WR, 8'h05, 0, "R7");

        // R2 shared fill, R11 no promotion of a sole Shared copy
        shared_next = 1'b1;
        expect_bus(B_RD, 8'h0A);
        do_cpu(RD, 8'h0A, 1, "R2");
        shared_next = 1'b0;
        do_cpu(RD, 8'h0A, 0, "R11");
        expect_bus(B_RFO, 8'h0A);
        do_cpu(WR, 8'h0A, 1, "R11");

        // R5 write miss over a dirty victim: write-back then one ownership read
        expect_bus(B_WB, 8'h0A);
        expect_bus(B_RFO, 8'h06);
        do_cpu(WR, 8'h06, 2, "R5");
        do_snoop(1'b0, 8'h0A, 1'b0, 1'b0, "R12");
        do_cpu(WR, 8'h06, 0, "R5");

        // R10 ownership snoop invalidates a Shared line
        shared_next = 1'b1;
        expect_bus(B_RD, 8'h03);
        do_cpu(RD, 8'h03, 1, "R2");
        do_snoop(1'b0, 8'h03, 1'b0, 1'b1, "R9");
        do_snoop(1'b1, 8'h03, 1'b0, 1'b0, "R10");
        expect_bus(B_RD, 8'h03);
        do_cpu(RD, 8'h03, 1, "R10");

        // R9 snooped read demotes Exclusive to Shared
        shared_next = 1'b0;
        expect_bus(B_RD, 8'h00);
        do_cpu(RD, 8'h00, 1, "R2");
        do_snoop(1'b0, 8'h00, 1'b0, 1'b1, "R9");
        expect_bus(B_RFO, 8'h00);
        do_cpu(WR, 8'h00, 1, "R9");

        // R8 ownership snoop of a Modified line, then R10 on the demoted copy
        expect_bus(B_WB, 8'h00);
        s = n_bus;
        do_snoop(1'b1, 8'h00, 1'b1, 1'b0, "R8");
        settle(s, 1, "R8");
        do_snoop(1'b1, 8'h00, 1'b0, 1'b0, "R10");
        expect_bus(B_RD, 8'h00);
        do_cpu(RD, 8'h00, 1, "R10");

        // R6 evictions and clean replacement
        expect_bus(B_RD, 8'h0F);
        do_cpu(RD, 8'h0F, 1, "R2");
        do_cpu(EV, 8'h0F, 0, "R6");
        expect_bus(B_RD, 8'h0F);
        do_cpu(RD, 8'h0F, 1, "R6");
        expect_bus(B_RD, 8'h0B);
        do_cpu(RD, 8'h0B, 1, "R6");
        expect_bus(B_WB, 8'h06);
        do_cpu(EV, 8'h06, 1, "R6");
        expect_bus(B_RD, 8'h06);
        do_cpu(RD, 8'h06, 1, "R6");
        do_snoop(1'b1, 8'h1E, 1'b0, 1'b0, "R12");
        do_cpu(RD, 8'h06, 0, "R12");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule